// File: doc/BRIEF.md
# Clock Gate Enable Bank with Set/Clear Aliases

This block holds one enable bit per gated clock and drives those bits straight to the clock-gating cells that sit beside it. Software reaches the bits through a simple single-cycle register bus. The same bit vector is visible at three word-aligned addresses in a small group:

- a read-only status word that reports which clocks currently run;
- a set word, where a write turns on the gates whose data bits are 1;
- a clear word, where a write turns off the gates whose data bits are 1.

Because of these aliases, software never needs a read-modify-write to change one gate. Two agents can therefore toggle different clocks without a lock.

Gate n always uses bit n, in every view and on the output vector. A parameter sets the value the enable vector takes out of reset, so clocks that must always run come up enabled. The bus word width equals the number of gates.

Top module: `cg_gate_bank`

## Requirements
- R1: While rst_ni is low and on the first cycle after it rises, gate_en_o equals RESET_VAL and bus_rdata_o is zero.
- R2: An accepted write to offset BASE_ADDR+4 (the set word) sets every gate whose data bit is 1. gate_en_o shows the change just after the clock edge that samples the write.
- R3: An accepted write to offset BASE_ADDR+8 (the clear word) clears every gate whose data bit is 1. The change shows just after the sampling edge.
- R4: Data bits that are 0 in a write to the set or clear word leave the matching gates unchanged.
- R5: An accepted read of offset BASE_ADDR+0 (the status word) returns gate_en_o on bus_rdata_o after the next clock edge. Bit n of that word is gate n.
- R6: Writes to the status offset, to any unmapped address and to any address with bits [1:0] nonzero leave gate_en_o unchanged.
- R7: Reads of the set or clear offset, or of any unmapped or misaligned address, return zero. In any cycle without an accepted read, bus_rdata_o is zero after the next edge.
- R8: While bus_valid_i is low, bus_write_i, bus_addr_i and bus_wdata_i have no effect on gate_en_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Register clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bus_valid_i | input | 1 | Bus request this cycle |
| bus_write_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | ADDR_W | Byte address |
| bus_wdata_i | input | N_GATES | Write data, bit n addresses gate n |
| bus_rdata_o | output | N_GATES | Read data, registered |
| gate_en_o | output | N_GATES | Registered enable, one bit per gated clock |

## Verification
The bench uses 8 gates. It sweeps all 256 data patterns through the set word, each time from a cleared state. This separates a missing set from a set that spills into neighbouring bits. It then sweeps all 256 patterns through the clear word from a fully enabled state, and clears through a partly enabled state, so a clear that disturbs the zero-mask bits is caught. Status reads follow the writes and are compared against the same model, which catches a bit reordering between views. Writes to the status offset, to unmapped and misaligned addresses, and with valid low are each followed by a status read, which confirms that no bit moved.

// File: rtl/cg_pkg.sv
package cg_pkg;
  // word offsets within the gate group
  localparam int unsigned OFS_STATUS = 0;
  localparam int unsigned OFS_SET    = 4;
  localparam int unsigned OFS_CLEAR  = 8;

  typedef enum logic [1:0] {
    SEL_NONE   = 2'd0,
    SEL_STATUS = 2'd1,
    SEL_SET    = 2'd2,
    SEL_CLEAR  = 2'd3
  } sel_e;
endpackage

// File: rtl/cg_addr_dec.sv
module cg_addr_dec #(
  parameter int unsigned           ADDR_W    = 8,
  parameter logic [ADDR_W-1:0]     BASE_ADDR = '0
) (
  input  logic              valid_i,
  input  logic              write_i,
  input  logic [ADDR_W-1:0] addr_i,
  output cg_pkg::sel_e      sel_o,
  output logic              wr_o,
  output logic              rd_o
);
  import cg_pkg::*;

  localparam logic [ADDR_W-1:0] A_STAT = BASE_ADDR + ADDR_W'(OFS_STATUS);
  localparam logic [ADDR_W-1:0] A_SET  = BASE_ADDR + ADDR_W'(OFS_SET);
  localparam logic [ADDR_W-1:0] A_CLR  = BASE_ADDR + ADDR_W'(OFS_CLEAR);

  always_comb begin
    sel_o = SEL_NONE;
    // full compare, so misaligned addresses fall through to SEL_NONE
    if (addr_i == A_STAT)     sel_o = SEL_STATUS;
    else if (addr_i == A_SET) sel_o = SEL_SET;
    else if (addr_i == A_CLR) sel_o = SEL_CLEAR;
  end

  assign wr_o = valid_i &  write_i;
  assign rd_o = valid_i & ~write_i;
endmodule

// File: rtl/cg_en_reg.sv
module cg_en_reg #(
  parameter int unsigned         N_GATES   = 32,
  parameter logic [N_GATES-1:0]  RESET_VAL = '0
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N_GATES-1:0] set_i,
  input  logic [N_GATES-1:0] clr_i,
  output logic [N_GATES-1:0] q_o
);
  for (genvar i = 0; i < N_GATES; i++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                    q_o[i] <= RESET_VAL[i];
      else if (set_i[i] || clr_i[i])  q_o[i] <= ~clr_i[i]; // clear dominates
    end
  end
endmodule

// File: rtl/cg_rd_mux.sv
module cg_rd_mux #(
  parameter int unsigned N_GATES = 32
) (
  input  logic               rd_i,
  input  cg_pkg::sel_e       sel_i,
  input  logic [N_GATES-1:0] state_i,
  output logic [N_GATES-1:0] data_o
);
  import cg_pkg::*;

  always_comb begin
    data_o = '0;
    if (rd_i && sel_i == SEL_STATUS) data_o = state_i;
  end
endmodule

// File: rtl/cg_gate_bank.sv
module cg_gate_bank #(
  parameter int unsigned         N_GATES   = 32,
  parameter int unsigned         ADDR_W    = 8,
  parameter logic [ADDR_W-1:0]   BASE_ADDR = '0,
  parameter logic [N_GATES-1:0]  RESET_VAL = '0
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               bus_valid_i,
  input  logic               bus_write_i,
  input  logic [ADDR_W-1:0]  bus_addr_i,
  input  logic [N_GATES-1:0] bus_wdata_i,
  output logic [N_GATES-1:0] bus_rdata_o,
  output logic [N_GATES-1:0] gate_en_o
);
  import cg_pkg::*;

  sel_e               sel;
  logic               wr, rd;
  logic [N_GATES-1:0] set_mask, clr_mask, rd_next;

  cg_addr_dec #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_dec (
    .valid_i (bus_valid_i),
    .write_i (bus_write_i),
    .addr_i  (bus_addr_i),
    .sel_o   (sel),
    .wr_o    (wr),
    .rd_o    (rd)
  );

  assign set_mask = (wr && sel == SEL_SET)   ? bus_wdata_i : '0;
  assign clr_mask = (wr && sel == SEL_CLEAR) ? bus_wdata_i : '0;

  cg_en_reg #(.N_GATES(N_GATES), .RESET_VAL(RESET_VAL)) u_en (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (set_mask),
    .clr_i  (clr_mask),
    .q_o    (gate_en_o)
  );

  cg_rd_mux #(.N_GATES(N_GATES)) u_rd (
    .rd_i    (rd),
    .sel_i   (sel),
    .state_i (gate_en_o),
    .data_o  (rd_next)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) bus_rdata_o <= '0;
    else         bus_rdata_o <= rd_next;
  end
endmodule

// File: rtl/cg_gate_bank_chk.sv
module cg_gate_bank_chk #(
  parameter int unsigned         N_GATES   = 32,
  parameter int unsigned         ADDR_W    = 8,
  parameter logic [ADDR_W-1:0]   BASE_ADDR = '0
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               bus_valid_i,
  input logic               bus_write_i,
  input logic [ADDR_W-1:0]  bus_addr_i,
  input logic [N_GATES-1:0] bus_wdata_i,
  input logic [N_GATES-1:0] bus_rdata_o,
  input logic [N_GATES-1:0] gate_en_o
);
  logic do_set, do_clr, rd_stat, rd_other;
  assign do_set   = bus_valid_i && bus_write_i && bus_addr_i == BASE_ADDR + ADDR_W'(4);
  assign do_clr   = bus_valid_i && bus_write_i && bus_addr_i == BASE_ADDR + ADDR_W'(8);
  assign rd_stat  = bus_valid_i && !bus_write_i && bus_addr_i == BASE_ADDR;
  assign rd_other = bus_valid_i && !bus_write_i && bus_addr_i != BASE_ADDR;

  a_r2_set_bits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    do_set |=> ((gate_en_o & $past(bus_wdata_i)) == $past(bus_wdata_i)));

  a_r3_clear_bits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    do_clr |=> ((gate_en_o & $past(bus_wdata_i)) == '0));

  a_r4_others_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (do_set || do_clr) |=>
      ((gate_en_o & ~$past(bus_wdata_i)) == ($past(gate_en_o) & ~$past(bus_wdata_i))));

  a_r6_no_write_no_change: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(do_set || do_clr) |=> $stable(gate_en_o));

  a_r5_status_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_stat |=> (bus_rdata_o == $past(gate_en_o)));

  a_r7_other_read_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_other || !bus_valid_i || bus_write_i) |=> (bus_rdata_o == '0));
endmodule

bind cg_gate_bank cg_gate_bank_chk #(
  .N_GATES(N_GATES), .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .bus_valid_i (bus_valid_i),
  .bus_write_i (bus_write_i),
  .bus_addr_i  (bus_addr_i),
  .bus_wdata_i (bus_wdata_i),
  .bus_rdata_o (bus_rdata_o),
  .gate_en_o   (gate_en_o)
);

// File: tb/sim_cg_gate_bank.sv
module sim_cg_gate_bank;
  localparam int unsigned N  = 8;
  localparam int unsigned AW = 8;
  localparam logic [AW-1:0] BASE = 8'h40;
  localparam logic [N-1:0]  RST  = 8'h81;
  localparam logic [AW-1:0] A_ST = BASE;
  localparam logic [AW-1:0] A_SE = BASE + 8'd4;
  localparam logic [AW-1:0] A_CL = BASE + 8'd8;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic bus_valid_i = 1'b0, bus_write_i = 1'b0;
  logic [AW-1:0] bus_addr_i = '0;
  logic [N-1:0]  bus_wdata_i = '0;
  logic [N-1:0]  bus_rdata_o, gate_en_o;

  int checks = 0, errors = 0;
  logic [N-1:0] model;
  logic done = 1'b0;

  always #5 clk_i = ~clk_i;

  cg_gate_bank #(.N_GATES(N), .ADDR_W(AW), .BASE_ADDR(BASE), .RESET_VAL(RST)) u0 (
    .clk_i, .rst_ni, .bus_valid_i, .bus_write_i, .bus_addr_i, .bus_wdata_i,
    .bus_rdata_o, .gate_en_o
  );

  task automatic chk(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // drive on negedge, sampled at posedge, result visible at next negedge
  task automatic bus_op(input logic v, input logic w, input logic [AW-1:0] a, input logic [N-1:0] d);
    @(negedge clk_i);
    bus_valid_i = v; bus_write_i = w; bus_addr_i = a; bus_wdata_i = d;
    @(posedge clk_i);
    @(negedge clk_i);
    bus_valid_i = 1'b0; bus_write_i = 1'b0; bus_addr_i = '0; bus_wdata_i = '0;
  endtask

  task automatic read_status(input string req);
    bus_op(1'b1, 1'b0, A_ST, '0);
    chk(req, bus_rdata_o, model);
  endtask

  initial begin
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    chk("R1 reset gate_en", gate_en_o, RST);
    chk("R1 reset rdata", bus_rdata_o, '0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 after release", gate_en_o, RST);
    model = RST;
    read_status("R5 status after reset");

    // R2 sweep: every pattern set from cleared state
    for (int p = 0; p < 256; p++) begin
      bus_op(1'b1, 1'b1, A_CL, '1); model = '0;
      bus_op(1'b1, 1'b1, A_SE, N'(p)); model = N'(p);
      chk("R2 set pattern", gate_en_o, model);
      if (p % 16 == 5) read_status("R5 status after set");
    end

    // R3 sweep: every pattern cleared from full state
    for (int p = 0; p < 256; p++) begin
      bus_op(1'b1, 1'b1, A_SE, '1); model = '1;
      bus_op(1'b1, 1'b1, A_CL, N'(p)); model = ~N'(p);
      chk("R3 clear pattern", gate_en_o, model);
    end

    // R4: zero bits preserve partial state
    for (int p = 0; p < 256; p += 7) begin
      bus_op(1'b1, 1'b1, A_CL, '1);
      bus_op(1'b1, 1'b1, A_SE, 8'h5A); model = 8'h5A;
      bus_op(1'b1, 1'b1, A_SE, N'(p)); model = model | N'(p);
      chk("R4 set keeps others", gate_en_o, model);
      bus_op(1'b1, 1'b1, A_CL, N'(p ^ 8'h33)); model = model & ~N'(p ^ 8'h33);
      chk("R4 clear keeps others", gate_en_o, model);
      read_status("R5 status partial");
    end

    // R6: ignored writes
    bus_op(1'b1, 1'b1, A_CL, '1);
    bus_op(1'b1, 1'b1, A_SE, 8'h3C); model = 8'h3C;
    bus_op(1'b1, 1'b1, A_ST, 8'hFF);
    chk("R6 status write ignored", gate_en_o, model);
    bus_op(1'b1, 1'b1, A_ST, 8'h00);
    chk("R6 status write zero ignored", gate_en_o, model);
    bus_op(1'b1, 1'b1, BASE + 8'd12, 8'hFF);
    chk("R6 unmapped write ignored", gate_en_o, model);
    bus_op(1'b1, 1'b1, A_SE + 8'd1, 8'hC3);
    chk("R6 misaligned set ignored", gate_en_o, model);
    bus_op(1'b1, 1'b1, A_CL + 8'd2, 8'hFF);
    chk("R6 misaligned clear ignored", gate_en_o, model);
    read_status("R6 status unchanged");

    // R7: zero reads
    bus_op(1'b1, 1'b0, A_SE, '0);
    chk("R7 set offset reads zero", bus_rdata_o, '0);
    bus_op(1'b1, 1'b0, A_CL, '0);
    chk("R7 clear offset reads zero", bus_rdata_o, '0);
    bus_op(1'b1, 1'b0, BASE + 8'd16, '0);
    chk("R7 unmapped reads zero", bus_rdata_o, '0);
    bus_op(1'b1, 1'b0, A_ST + 8'd1, '0);
    chk("R7 misaligned reads zero", bus_rdata_o, '0);
    read_status("R5 status nonzero");
    bus_op(1'b0, 1'b0, A_ST, '0);
    chk("R7 idle rdata zero", bus_rdata_o, '0);

    // R8: valid low
    bus_op(1'b0, 1'b1, A_SE, 8'hFF);
    chk("R8 set with valid low", gate_en_o, model);
    bus_op(1'b0, 1'b1, A_CL, 8'hFF);
    chk("R8 clear with valid low", gate_en_o, model);
    read_status("R8 status unchanged");

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk_i);
        errors++; checks++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule